// File: doc/BRIEF.md
# Receive Buffer False-Bottom Checker

This block keeps track of how many 16-bit words are still free in the receive buffer that is currently being filled. Each time the receive datapath stores a word into the buffer, the block lowers the free count. The step is one in 16-bit bus mode and two in 32-bit bus mode. When a fresh buffer is handed over, its full word count is loaded and tracking starts again.

The block holds a programmable floor register, which is the largest packet the system expects, measured in 16-bit words. It resets to 0x2F8, which is 760 words or 1520 bytes. At the end of every packet the block compares the free count with this floor. In 32-bit mode bit 0 of the floor is taken as zero for this comparison. If the free count is strictly below the floor, the next packet might not fit. The block then sends a single-cycle request to the resource fetcher to move to a new buffer. Because of this, a packet always starts in a buffer with room for a packet of maximum size, and no packet is split over two buffers.

After a request, further requests are held back until the next buffer count is loaded. A load in the same cycle as a packet end cancels the switch decision.

Top module: `rxbuf_floor_guard`

## Requirements
- R1: After reset, `floor_value` reads 0x2F8, `words_left` reads 0 and `switch_req` is low.
- R2: A cycle with `floor_wr` high makes `floor_value` equal `floor_wdata` on the following cycle.
- R3: A cycle with `buf_load` high makes `words_left` equal `buf_words` on the following cycle, whatever `word_stb` does in that cycle.
- R4: With `bus_mode` = 0 (16-bit), each cycle with `word_stb` high and `buf_load` low lowers `words_left` by 1.
- R5: With `bus_mode` = 1 (32-bit), each cycle with `word_stb` high and `buf_load` low lowers `words_left` by 2.
- R6: `words_left` never wraps: a decrement larger than the count leaves it at 0.
- R7: A cycle with `pkt_end` high, `buf_load` low and no request outstanding raises `switch_req` for exactly one cycle on the next cycle, if the free count after that cycle's word store is below the floor. Otherwise `switch_req` stays low.
- R8: In 32-bit mode the floor's bit 0 counts as 0 in the comparison. With a floor of 759 and a count of 758, a request is raised in 16-bit mode and none in 32-bit mode.
- R9: A free count equal to the effective floor raises no request.
- R10: After a request, later packet ends raise no request until a `buf_load` cycle has occurred.
- R11: A `buf_load` in the same cycle as `pkt_end` cancels the request, and any outstanding request is cleared.
- R12: Word stores that take the count below the floor raise no request without `pkt_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_mode | input | 1 | 0 = 16-bit words, 1 = 32-bit words |
| floor_wr | input | 1 | Write strobe for the floor register |
| floor_wdata | input | 16 | New floor value in 16-bit words |
| buf_load | input | 1 | A new buffer's word count is presented |
| buf_words | input | 32 | Word count of the new buffer |
| word_stb | input | 1 | One bus word was stored into the buffer |
| pkt_end | input | 1 | Last word of a packet was stored this cycle |
| floor_value | output | 16 | Current floor register contents |
| words_left | output | 32 | Free 16-bit words left in the active buffer |
| switch_req | output | 1 | One-cycle request for a new buffer |

## Verification
The assertions assume that `bus_mode` only changes between packets and that the floor register is not rewritten while a packet is being stored. The decrement and comparison checks do not model a mode or floor change in the middle of a packet. The bench respects this: it sets the mode and the floor before each scenario's buffer load and keeps them fixed until the scenario ends. The checks that cover a whole buffer also assume that `pkt_end` comes only after a fresh load has cleared any outstanding request. The bench follows this ordering, except in the scenarios that test suppression on purpose.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    parameter int CNT_W = 32;
    parameter int FLR_W = 16;
    parameter logic [FLR_W-1:0] FLR_RESET = 16'h02F8;

    typedef enum logic {
        MODE_W16 = 1'b0,
        MODE_W32 = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             loaded;
    } cnt_state_t;

    function automatic logic [1:0] word_step(bus_mode_e m);
        return (m == MODE_W32) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [FLR_W-1:0] floor_for_mode(logic [FLR_W-1:0] f, bus_mode_e m);
        return (m == MODE_W32) ? {f[FLR_W-1:1], 1'b0} : f;
    endfunction

endpackage

// File: rtl/rbf_floor_reg.sv
module rbf_floor_reg
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [FLR_W-1:0] wr_data,
    input  bus_mode_e        mode,
    output logic [FLR_W-1:0] floor_raw,
    output logic [FLR_W-1:0] floor_eff
);

    always_ff @(posedge clk) begin
        if (rst)
            floor_raw <= FLR_RESET;
        else if (wr_en)
            floor_raw <= wr_data;
    end

    always_comb floor_eff = floor_for_mode(floor_raw, mode);

    // R1
    floor_reset_chk: assert property (@(posedge clk) rst |=> floor_raw == FLR_RESET);

    // R2
    floor_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> floor_raw == $past(wr_data));

endmodule

// File: rtl/rbf_word_counter.sv
module rbf_word_counter
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             word_stb,
    input  bus_mode_e        mode,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_next
);

    localparam int PAD_W = CNT_W - 2;

    cnt_state_t       st_next;
    logic [CNT_W-1:0] step;

    always_comb begin
        step    = {{PAD_W{1'b0}}, word_step(mode)};
        st_next = '{count: count_q, loaded: 1'b0};
        if (load) begin
            st_next.count  = load_val;
            st_next.loaded = 1'b1;
        end else if (word_stb) begin
            st_next.count = (count_q > step) ? count_q - step : '0;
        end
        count_next = st_next.count;
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else
            count_q <= count_next;
    end

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> count_q == $past(load_val));

    // R4
    dec16_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && word_stb && mode == MODE_W16 && count_q != '0) |=> count_q + 1 == $past(count_q));

    // R5
    dec32_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && word_stb && mode == MODE_W32 && count_q > 1) |=> count_q + 2 == $past(count_q));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && word_stb) |=> count_q < $past(count_q) || count_q == '0);

    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !word_stb) |=> $stable(count_q));

endmodule

// File: rtl/rbf_switch_ctl.sv
module rbf_switch_ctl
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_end,
    input  logic             load,
    input  logic [CNT_W-1:0] count_next,
    input  logic [FLR_W-1:0] floor_eff,
    output logic             req
);

    localparam int EXT_W = CNT_W - FLR_W;

    logic             wait_q;
    logic             below;
    logic             fire;
    logic [CNT_W-1:0] floor_ext;

    always_comb begin
        floor_ext = {{EXT_W{1'b0}}, floor_eff};
        below     = count_next < floor_ext;
        fire      = pkt_end && !load && !wait_q && below;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req    <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            req    <= fire;
            wait_q <= load ? 1'b0 : (wait_q | fire);
        end
    end

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R12
    req_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(pkt_end));

    // R10
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_q && !load) |=> !req);

    // R11
    load_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !req && !wait_q);

endmodule

// File: rtl/rxbuf_floor_guard.sv
module rxbuf_floor_guard
    import rbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_mode,
    input  logic             floor_wr,
    input  logic [FLR_W-1:0] floor_wdata,
    input  logic             buf_load,
    input  logic [CNT_W-1:0] buf_words,
    input  logic             word_stb,
    input  logic             pkt_end,
    output logic [FLR_W-1:0] floor_value,
    output logic [CNT_W-1:0] words_left,
    output logic             switch_req
);

    bus_mode_e        mode;
    logic [FLR_W-1:0] floor_eff;
    logic [CNT_W-1:0] count_next;

    always_comb mode = bus_mode_e'(bus_mode);

    rbf_floor_reg u_floor (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (floor_wr),
        .wr_data   (floor_wdata),
        .mode      (mode),
        .floor_raw (floor_value),
        .floor_eff (floor_eff)
    );

    rbf_word_counter u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (buf_load),
        .load_val   (buf_words),
        .word_stb   (word_stb),
        .mode       (mode),
        .count_q    (words_left),
        .count_next (count_next)
    );

    rbf_switch_ctl u_switch (
        .clk        (clk),
        .rst        (rst),
        .pkt_end    (pkt_end),
        .load       (buf_load),
        .count_next (count_next),
        .floor_eff  (floor_eff),
        .req        (switch_req)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !switch_req && words_left == '0);

endmodule

// File: tb/sim_rxbuf_floor_guard.sv
module sim_rxbuf_floor_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_mode = 1'b0;
    logic        floor_wr = 1'b0;
    logic [15:0] floor_wdata = '0;
    logic        buf_load = 1'b0;
    logic [31:0] buf_words = '0;
    logic        word_stb = 1'b0;
    logic        pkt_end = 1'b0;
    logic [15:0] floor_value;
    logic [31:0] words_left;
    logic        switch_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rxbuf_floor_guard u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_mode    (bus_mode),
        .floor_wr    (floor_wr),
        .floor_wdata (floor_wdata),
        .buf_load    (buf_load),
        .buf_words   (buf_words),
        .word_stb    (word_stb),
        .pkt_end     (pkt_end),
        .floor_value (floor_value),
        .words_left  (words_left),
        .switch_req  (switch_req)
    );

    task automatic chk(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives one cycle of inputs, lets the edge pass, then clears them.
    task automatic cyc(bit ld, int unsigned words, bit ws, bit pe);
        buf_load  = ld;
        buf_words = words;
        word_stb  = ws;
        pkt_end   = pe;
        @(posedge clk);
        #1;
        buf_load = 1'b0;
        word_stb = 1'b0;
        pkt_end  = 1'b0;
    endtask

    task automatic set_floor(int unsigned v);
        floor_wr    = 1'b1;
        floor_wdata = 16'(v);
        @(posedge clk);
        #1;
        floor_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 floor", floor_value, 'h2F8);
        chk("R1 words", words_left, 0);
        chk("R1 req", switch_req, 0);
    endtask

    task automatic t_floor_write();
        set_floor(759);
        chk("R2 floor write", floor_value, 759);
    endtask

    task automatic t_count16();
        bus_mode = 1'b0;
        cyc(1, 1000, 0, 0);
        chk("R3 load", words_left, 1000);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
        chk("R4 dec by one", words_left, 997);
        cyc(1, 500, 1, 0);
        chk("R3 load beats store", words_left, 500);
    endtask

    task automatic t_count32();
        bus_mode = 1'b1;
        cyc(1, 100, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        chk("R5 dec by two", words_left, 96);
    endtask

    task automatic t_saturate();
        bus_mode = 1'b1;
        cyc(1, 1, 0, 0);
        cyc(0, 0, 1, 0);
        chk("R6 floor at zero 32", words_left, 0);
        bus_mode = 1'b0;
        cyc(0, 0, 1, 0);
        chk("R6 floor at zero 16", words_left, 0);
    endtask

    task automatic t_switch16();
        bus_mode = 1'b0;
        set_floor(759);
        cyc(1, 800, 0, 0);
        cyc(0, 0, 0, 1);
        chk("R7 above floor", switch_req, 0);
        cyc(1, 759, 0, 0);
        cyc(0, 0, 0, 1);
        chk("R9 equal floor", switch_req, 0);
        cyc(1, 760, 0, 0);
        cyc(0, 0, 1, 1);
        chk("R9 equal after store", switch_req, 0);
        cyc(1, 759, 0, 0);
        cyc(0, 0, 1, 1);
        chk("R7 request raised", switch_req, 1);
        cyc(0, 0, 0, 0);
        chk("R7 one cycle", switch_req, 0);
        cyc(0, 0, 0, 1);
        chk("R10 held off", switch_req, 0);
        cyc(1, 700, 0, 0);
        chk("R11 load clears", switch_req, 0);
        cyc(0, 0, 0, 1);
        chk("R10 rearmed by load", switch_req, 1);
        cyc(1, 2000, 0, 0);
    endtask

    task automatic t_mask32();
        set_floor(759);
        bus_mode = 1'b1;
        cyc(1, 758, 0, 0);
        cyc(0, 0, 0, 1);
        chk("R8 32-bit masked", switch_req, 0);
        bus_mode = 1'b0;
        cyc(0, 0, 0, 1);
        chk("R8 16-bit full", switch_req, 1);
        cyc(1, 2000, 0, 0);
    endtask

    task automatic t_load_cancel();
        bus_mode = 1'b0;
        set_floor(759);
        cyc(1, 100, 0, 1);
        chk("R11 same-cycle load", switch_req, 0);
        cyc(0, 0, 0, 0);
        chk("R11 stays low", switch_req, 0);
        cyc(1, 2000, 0, 0);
    endtask

    task automatic t_no_end();
        bit seen = 1'b0;
        bus_mode = 1'b0;
        set_floor(759);
        cyc(1, 762, 0, 0);
        for (int i = 0; i < 10; i++) begin
            cyc(0, 0, 1, 0);
            if (switch_req) seen = 1'b1;
        end
        chk("R12 words left", words_left, 752);
        chk("R12 no request", seen, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_floor_write();
        t_count16();
        t_count32();
        t_saturate();
        t_switch16();
        t_mask32();
        t_load_cancel();
        t_no_end();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule